// File: doc/BRIEF.md
# Programmable Baud-Rate Tick Divider

This block turns a free-running reference enable into a strobe at sixteen times the serial bit rate. The division ratio is a 16-bit value that software writes as two bytes through a small byte-wide register bus. A bank-select bit in the line-setup register decides what the two lowest bus addresses mean. With the bit set, they reach the low and high divisor bytes. With it clear, the same addresses reach the serial data byte and the interrupt-enable byte.

Inside, a down-counter counts reference enables and produces a one-cycle tick each time it has counted the programmed divisor. Writing either divisor byte reloads the counter at once from the updated value. A new rate therefore takes effect on the very next enables, and the counter never finishes a long count from the old value first. A divisor of zero, which is also the reset value, stops the ticks.

Top module: `baud_div_top`

## Requirements
- R1: After reset, both divisor bytes, the line-setup register, the interrupt-enable byte and the transmit byte all read or show 0, and `baud_tick` is low.
- R2: While the divisor is 0, `baud_tick` stays low whatever `ref_en` does, and the counter holds.
- R3: With divisor D ≥ 1, `baud_tick` rises once every D cycles in which `ref_en` is high. The tick appears in the cycle after the `ref_en` cycle that completes the count, lasts exactly one cycle, and never appears after a cycle with `ref_en` low.
- R4: With divisor 1, every cycle with `ref_en` high is followed by a tick, so a continuously high `ref_en` gives a continuously high `baud_tick`.
- R5: A write to either divisor byte loads the counter with the full updated divisor in the same cycle, discarding the count in progress. The first tick after the write follows exactly D enables.
- R6: Address 3 is the line-setup register. It reads back the value last written, and its bit 7 is the bank-select bit.
- R7: With bank select at 1, address 0 reaches divisor bits 7:0 and address 1 reaches divisor bits 15:8. A read returns the byte last written, never the running count.
- R8: With bank select at 0, a write to address 0 updates `tx_byte` and pulses `tx_load` high for the following cycle. A read of address 0 returns `rx_byte` and drives `rx_take` high in that cycle. Address 1 writes and reads the interrupt-enable byte shown on `int_en`.
- R9: With bank select at 0, writes to addresses 0 and 1 leave the divisor unchanged. With bank select at 1, they leave `tx_byte`, `tx_load` and `int_en` unchanged.
- R10: Addresses 2 and 4 through 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_en | input | 1 | Reference enable; each high cycle advances the divider by one |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address and bank) |
| rx_byte | input | 8 | Received byte presented by the receive path |
| rx_take | output | 1 | High while the receive byte is being read |
| tx_byte | output | 8 | Last byte written for transmission |
| tx_load | output | 1 | One-cycle pulse after a transmit byte write |
| int_en | output | 8 | Interrupt-enable byte |
| line_ctrl | output | 8 | Line-setup register, bit 7 is bank select |
| baud_tick | output | 1 | One-cycle tick at sixteen times the bit rate |

## Verification
A corrupted divisor latch shows up on the first read-back of that byte. It also shows up within one tick period as a wrong count of enables between ticks. A counter that misses a reload or decrements wrongly moves the next tick by at least one enable. This is visible at most D enables after the write. A wrong bank decode shows in the same cycle as a wrong `bus_rdata`, or one cycle later as a stray change on `tx_byte`, `tx_load` or `int_en`.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DIV_BYTES = 2;
  localparam int unsigned DIV_W     = REG_W * DIV_BYTES;
  localparam int unsigned BANK_BIT  = 7;

  localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_INTEN = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LINE  = 3'd3;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic inten_wr;
    logic line_wr;
  } bus_dec_t;
endpackage

// File: rtl/baud_div_rst_sync.sv
module baud_div_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  rx_byte,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rx_take,
  output logic [REG_W-1:0]  tx_byte,
  output logic              tx_load,
  output logic [REG_W-1:0]  int_en,
  output logic [REG_W-1:0]  line_ctrl,
  output logic [DIV_W-1:0]  divisor,
  output logic [DIV_W-1:0]  div_next,
  output logic              div_load
);
  logic                 bank;
  bus_dec_t             dec;
  logic [DIV_BYTES-1:0] div_hit;
  logic [DIV_BYTES-1:0] div_we;

  logic [REG_W-1:0] line_q, line_d;
  logic [REG_W-1:0] inten_q, inten_d;
  logic [REG_W-1:0] tx_q, tx_d;
  logic             txl_q, txl_d;
  logic [REG_W-1:0] rdata_c;

  assign bank = line_q[BANK_BIT];

  // Bus decode for the non-divisor registers
  always_comb begin
    dec          = '0;
    dec.data_wr  = bus_wr && !bank && (bus_addr == ADR_DATA);
    dec.data_rd  = bus_rd && !bank && (bus_addr == ADR_DATA);
    dec.inten_wr = bus_wr && !bank && (bus_addr == ADR_INTEN);
    dec.line_wr  = bus_wr && (bus_addr == ADR_LINE);
  end

  // One latch per divisor byte, byte b sits at address b in the divisor bank
  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_byte
    logic [REG_W-1:0] byte_q, byte_d;

    assign div_hit[b] = bank && (bus_addr == ADDR_W'(b));
    assign div_we[b]  = bus_wr && div_hit[b];

    always_comb byte_d = div_we[b] ? bus_wdata : byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign divisor[b*REG_W +: REG_W]  = byte_q;
    assign div_next[b*REG_W +: REG_W] = byte_d;
  end

  assign div_load = |div_we;

  // Next-state for the control and data registers
  always_comb begin
    line_d  = dec.line_wr  ? bus_wdata : line_q;
    inten_d = dec.inten_wr ? bus_wdata : inten_q;
    tx_d    = dec.data_wr  ? bus_wdata : tx_q;
    txl_d   = dec.data_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      inten_q <= '0;
      tx_q    <= '0;
      txl_q   <= 1'b0;
    end else begin
      line_q  <= line_d;
      inten_q <= inten_d;
      tx_q    <= tx_d;
      txl_q   <= txl_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_c = '0;
    for (int b = 0; b < DIV_BYTES; b++) begin
      if (div_hit[b]) rdata_c = divisor[b*REG_W +: REG_W];
    end
    if (!bank && (bus_addr == ADR_DATA))  rdata_c = rx_byte;
    if (!bank && (bus_addr == ADR_INTEN)) rdata_c = inten_q;
    if (bus_addr == ADR_LINE)             rdata_c = line_q;
  end

  assign bus_rdata = rdata_c;
  assign rx_take   = dec.data_rd;
  assign tx_byte   = tx_q;
  assign tx_load   = txl_q;
  assign int_en    = inten_q;
  assign line_ctrl = line_q;
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [DIV_W-1:0] div_next,
  input  logic             div_load,
  output logic [DIV_W-1:0] count,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             run;

  assign run = ref_en && (divisor != '0);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (div_load) begin
      cnt_d = div_next;
    end else if (run) begin
      if (cnt_q <= ONE) begin
        cnt_d  = divisor;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign count = cnt_q;
  assign tick  = tick_q;
endmodule

// File: rtl/baud_div_top.sv
module baud_div_top
  import baud_div_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_en,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  rx_byte,
  output logic        rx_take,
  output logic [7:0]  tx_byte,
  output logic        tx_load,
  output logic [7:0]  int_en,
  output logic [7:0]  line_ctrl,
  output logic        baud_tick
);
  logic             rst_ns;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] div_next;
  logic             div_load;
  logic [DIV_W-1:0] count;

  baud_div_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  baud_div_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_byte   (rx_byte),
    .bus_rdata (bus_rdata),
    .rx_take   (rx_take),
    .tx_byte   (tx_byte),
    .tx_load   (tx_load),
    .int_en    (int_en),
    .line_ctrl (line_ctrl),
    .divisor   (divisor),
    .div_next  (div_next),
    .div_load  (div_load)
  );

  baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .ref_en   (ref_en),
    .divisor  (divisor),
    .div_next (div_next),
    .div_load (div_load),
    .count    (count),
    .tick     (baud_tick)
  );
endmodule

// File: rtl/baud_div_chk.sv
module baud_div_chk
  import baud_div_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [REG_W-1:0]  line_ctrl,
  input logic [DIV_W-1:0]  divisor,
  input logic [DIV_W-1:0]  count,
  input logic              div_load,
  input logic              baud_tick
);
  // R2
  zero_div_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !baud_tick);

  // R3
  tick_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(ref_en));

  // R3
  tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && (divisor > DIV_W'(1))) |=> !baud_tick);

  // R5
  reload_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> (count == divisor));

  // R6
  line_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADR_LINE)) |=> (line_ctrl == $past(bus_wdata)));

  // R9
  divisor_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !line_ctrl[BANK_BIT] && (bus_addr != ADR_LINE)) |=> $stable(divisor));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == 3'd2) || (bus_addr >= 3'd4)) |-> (bus_rdata == '0));
endmodule

bind baud_div_top baud_div_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .ref_en    (ref_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .line_ctrl (line_ctrl),
  .divisor   (divisor),
  .count     (count),
  .div_load  (div_load),
  .baud_tick (baud_tick)
);

// File: tb/baud_div_top_tb.sv
`timescale 1ns/1ps
module baud_div_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_en;
  logic       bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rx_byte;
  logic       rx_take, tx_load, baud_tick;
  logic [7:0] tx_byte, int_en, line_ctrl;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  baud_div_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_take(rx_take),
    .tx_byte(tx_byte), .tx_load(tx_load),
    .int_en(int_en), .line_ctrl(line_ctrl), .baud_tick(baud_tick)
  );

  // divisor in [19:4], idle cycles between enables in [3:0]
  localparam logic [19:0] VECS [0:8] = '{
    {16'd1,   4'd0}, {16'd2,   4'd0}, {16'd3,   4'd2},
    {16'd7,   4'd1}, {16'd16,  4'd0}, {16'd255, 4'd0},
    {16'd256, 4'd3}, {16'd258, 4'd1}, {16'd300, 4'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic take);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata; take = rx_take;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_div(input logic [15:0] dv);
    wr(3'd3, 8'h80);
    wr(3'd0, dv[7:0]);
    wr(3'd1, dv[15:8]);
  endtask

  // Pulses ref_en until a tick is seen; returns number of enables, stray ticks
  task automatic run_period(input int limit, input int idle, output int n, output int stray);
    bit seen = 0;
    n = 0; stray = 0;
    while (!seen && n < limit) begin
      @(negedge clk) ref_en = 1'b1;
      n++;
      @(negedge clk) ref_en = 1'b0;
      if (baud_tick) seen = 1;
      for (int k = 0; k < idle; k++) begin
        @(negedge clk);
        if (baud_tick) stray++;
      end
    end
    @(negedge clk);
    if (baud_tick) stray++;
    if (!seen) n = -1;
  endtask

  task automatic pulses(input int cnt, output int ticks);
    ticks = 0;
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk) ref_en = 1'b1;
      @(negedge clk) ref_en = 1'b0;
      if (baud_tick) ticks++;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       tk;
    int n, stray, ticks;

    rst_n = 1'b0; ref_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(baud_tick == 0, "R1 tick", baud_tick, 0);
    check(line_ctrl == 0 && int_en == 0 && tx_byte == 0, "R1 regs",
          {line_ctrl, int_en, tx_byte}, 0);
    rd(3'd3, d, tk); check(d == 0, "R1 line read", d, 0);
    wr(3'd3, 8'h80);
    rd(3'd0, d, tk); check(d == 0, "R1 div low", d, 0);
    rd(3'd1, d, tk); check(d == 0, "R1 div high", d, 0);

    // R2 zero divisor: no ticks
    pulses(40, ticks);
    check(ticks == 0, "R2 zero divisor", ticks, 0);

    // R7 read back latches, not counter
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, d, tk); check(d == 8'h34, "R7 low byte", d, 8'h34);
    rd(3'd1, d, tk); check(d == 8'h12, "R7 high byte", d, 8'h12);
    pulses(9, ticks);
    rd(3'd0, d, tk); check(d == 8'h34, "R7 latch not counter", d, 8'h34);
    check(tk == 0, "R9 no rx_take in divisor bank", tk, 0);

    // R6 line register, bank 0
    wr(3'd3, 8'h03);
    rd(3'd3, d, tk); check(d == 8'h03, "R6 line readback", d, 8'h03);

    // R8 data / interrupt-enable bank
    wr(3'd0, 8'hA5);
    check(tx_byte == 8'hA5 && tx_load == 1, "R8 tx write", {tx_load, tx_byte}, 9'h1A5);
    @(negedge clk);
    check(tx_load == 0, "R8 tx_load one cycle", tx_load, 0);
    wr(3'd1, 8'h0F);
    check(int_en == 8'h0F, "R8 int_en", int_en, 8'h0F);
    rd(3'd1, d, tk); check(d == 8'h0F, "R8 int_en read", d, 8'h0F);
    rx_byte = 8'h5A;
    rd(3'd0, d, tk);
    check(d == 8'h5A && tk == 1, "R8 rx read", {tk, d}, 9'h15A);

    // R9 bank isolation
    wr(3'd3, 8'h80);
    rd(3'd0, d, tk); check(d == 8'h34, "R9 div low kept", d, 8'h34);
    rd(3'd1, d, tk); check(d == 8'h12, "R9 div high kept", d, 8'h12);
    wr(3'd0, 8'h34);
    check(tx_load == 0 && tx_byte == 8'hA5, "R9 tx kept", {tx_load, tx_byte}, 9'h0A5);
    wr(3'd1, 8'h12);
    check(int_en == 8'h0F, "R9 int_en kept", int_en, 8'h0F);

    // R10 unmapped addresses
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    for (int a = 2; a < 8; a++) begin
      if (a != 3) begin
        rd(3'(a), d, tk); check(d == 0, "R10 unmapped read", d, 0);
      end
    end
    check(line_ctrl == 8'h80 && int_en == 8'h0F && tx_byte == 8'hA5,
          "R10 no side effect", line_ctrl, 8'h80);
    rd(3'd0, d, tk); check(d == 8'h34, "R10 divisor kept", d, 8'h34);

    // R3 / R5 table walk: first period after load, then steady period
    for (int v = 0; v < 9; v++) begin
      int dv, idl;
      dv  = int'(VECS[v][19:4]);
      idl = int'(VECS[v][3:0]);
      set_div(16'(dv));
      run_period(dv + 4, idl, n, stray);
      check(n == dv, "R5 first period after load", n, dv);
      check(stray == 0, "R3 tick width/enable", stray, 0);
      run_period(dv + 4, idl, n, stray);
      check(n == dv, "R3 steady period", n, dv);
    end

    // R4 divisor one with continuous enable
    set_div(16'd1);
    @(negedge clk) ref_en = 1'b1;
    ticks = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (baud_tick) ticks++;
    end
    ref_en = 1'b0;
    check(ticks == 8, "R4 tick every enable", ticks, 8);
    @(negedge clk);
    check(baud_tick == 0, "R3 no tick without enable", baud_tick, 0);

    // R5 mid-count reload
    set_div(16'd200);
    pulses(30, ticks);
    check(ticks == 0, "R5 long count running", ticks, 0);
    wr(3'd0, 8'd5);
    run_period(12, 0, n, stray);
    check(n == 5, "R5 immediate reload", n, 5);

    // R2 back to zero: counter holds, ticks stop
    set_div(16'd0);
    pulses(20, ticks);
    check(ticks == 0, "R2 zero after running", ticks, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule